// File: doc/BRIEF.md
# Lockable GPIO Port Controller

This block is a register-mapped general purpose I/O controller for up to sixteen pins. Each pin has a configuration word that sets its direction, its pull selection and its function select code. The output latch can be reached one pin at a time or as a single 16-bit port word, and both views share the same storage. Pad levels pass through a two-flop synchronizer before software can read them. For a pin that is driving, the readback shows what the pad actually carries, not what the latch holds.

A small group of the low-numbered inputs can be routed through a programmable glitch filter. The filter counts ticks of a shared prescaler. Its output then feeds edge detectors, which have per-pin rising and falling enables, write-1-to-clear status bits and one combined interrupt line. Software can protect the configuration group (pin configuration, filter setup and edge enables) in two ways. A soft lock can be set and cleared at will. A hard lock stays set until reset. A write to a protected register is dropped and sets a sticky error flag. Data, status and lock writes and all reads are never blocked.

The register port is a single-cycle write strobe with a combinational read mux. A write takes effect on the clock edge where the strobe is high. The internal reset is asserted asynchronously and released two clocks after `rst_ni` rises.

Top module: `gpio_lock_ctrl`

## Requirements
- R1: After reset, every register reads 0. `pad_oe_o`, `pad_out_o`, `pad_pull_o`, `pad_func_o` and `irq_o` are all 0.
- R2: The configuration word of pin i sits at address 0x00+i. Bit 0 is direction (1 = output), bits [2:1] are the pull code (00 none, 01 pull-down, 10 pull-up) and bits [4:3] are the function select (00 = plain GPIO). A write shows on `pad_pull_o[2i+1:2i]` and `pad_func_o[2i+1:2i]` on the next cycle. `pad_oe_o[i]` is high exactly when direction is 1 and the function select is 00.
- R3: Address 0x10+i bit 0 and the port word at 0x30 both read and write the same output latch. `pad_out_o` shows that latch one cycle after the write.
- R4: Address 0x20+i bit 0 and the port word at 0x31 return `pad_in_i` delayed by two clocks, whatever the pin drives.
- R5: The filter register at 0x33 has three fields. Bits [NFILT-1:0] enable the filters, bits [11:8] hold L and bits [23:16] hold P. The prescaler ticks once every P+1 clocks. An enabled filter takes a new synchronized level only on the (L+1)-th tick that finds the level different from its output, and any cycle where the level matches restarts the count. A disabled filter follows the synchronized level with one clock of delay.
- R6: Rising enables sit at 0x34 and falling enables at 0x35. An enabled edge on a filter output sets the matching bit at 0x36. Writing 1 to a status bit clears it, and a new edge in the same cycle wins over the clear. `irq_o` is the OR of all status bits.
- R7: Bit 0 of the lock register at 0x32 is the soft lock, and it is freely writable. While it is set, writes to 0x00-0x0F, 0x33, 0x34 and 0x35 leave those registers unchanged.
- R8: Writing 1 to lock bit 1 sets the hard lock. It blocks the same writes as R7, and no write clears it before reset.
- R9: A blocked write sets lock bit 2, which stays set until a lock write with bit 2 = 1 clears it. Output data and status writes still take effect while locked.
- R10: Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pad_in_i | input | NPINS | Sensed pad levels |
| pad_out_o | output | NPINS | Output latch to pads |
| pad_oe_o | output | NPINS | Pad output enables |
| pad_pull_o | output | 2*NPINS | Pull code per pin |
| pad_func_o | output | 2*NPINS | Function select per pin |
| irq_o | output | 1 | OR of edge status bits |

## Verification
A wrong filter count or prescaler phase shows up as a status bit or `irq_o` rising some cycles early or late. A reference model that is compared on every clock catches this within one prescaler period. A lock that leaks lets a configuration change reach `pad_oe_o` or `pad_pull_o` on the next cycle. A lock that is too strict leaves the error flag or an output latch wrong when the next read comes. Synchronizer depth errors move the input readback by a cycle, and this shows at the first read after a pad change.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam logic [7:0] A_CFG      = 8'h00;
  localparam logic [7:0] A_DOUT     = 8'h10;
  localparam logic [7:0] A_DIN      = 8'h20;
  localparam logic [7:0] A_PORT_OUT = 8'h30;
  localparam logic [7:0] A_PORT_IN  = 8'h31;
  localparam logic [7:0] A_LOCK     = 8'h32;
  localparam logic [7:0] A_FILT     = 8'h33;
  localparam logic [7:0] A_RISE     = 8'h34;
  localparam logic [7:0] A_FALL     = 8'h35;
  localparam logic [7:0] A_STAT     = 8'h36;

  typedef struct packed {
    logic [1:0] func;
    logic [1:0] pull;
    logic       dir;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             din_i,
  output logic             dout_o
);
  logic             lvl_q, lvl_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      lvl_d = din_i;
      cnt_d = '0;
    end else if (din_i == lvl_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == len_i) begin
        lvl_d = din_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout_o = lvl_q;

  // R5
  filt_tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(dout_o));

  // R5
  filt_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (dout_o == $past(din_i)));
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] prev_q, stat_q, stat_d, set_w;

  assign set_w = (lvl_i & ~prev_q & rise_en_i) | (~lvl_i & prev_q & fall_en_i);

  always_comb begin
    stat_d = set_w | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  // R6
  stat_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q | set_w)) == '0));

  // R6
  stat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~stat_q & $past(stat_q & ~clr_i)) == '0));
endmodule

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_lock_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NFILT = 4,
  parameter int LEN_W = 4,
  parameter int PRE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [7:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NPINS-1:0]   pad_in_i,
  output logic [NPINS-1:0]   pad_out_o,
  output logic [NPINS-1:0]   pad_oe_o,
  output logic [2*NPINS-1:0] pad_pull_o,
  output logic [2*NPINS-1:0] pad_func_o,
  output logic               irq_o
);
  localparam logic [7:0] NP8 = 8'(NPINS);

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  pin_cfg_t [NPINS-1:0] cfg_q, cfg_d;
  logic [NPINS-1:0] dout_q, dout_d;
  logic             soft_q, soft_d, hard_q, hard_d, werr_q, werr_d;
  logic [NFILT-1:0] fen_q, fen_d, ren_q, ren_d, fal_q, fal_d;
  logic [LEN_W-1:0] flen_q, flen_d;
  logic [PRE_W-1:0] pre_q, pre_d, pcnt_q, pcnt_d;

  logic [NPINS-1:0] sync_w;
  logic [NFILT-1:0] flt_w, stat_w, stat_clr;
  logic             tick;
  logic [3:0]       idx;
  logic             hit_cfg, hit_dout, hit_din, guarded, locked, blocked;

  assign idx      = addr_i[3:0];
  assign hit_cfg  = (addr_i >= A_CFG)  && (addr_i < A_CFG + NP8);
  assign hit_dout = (addr_i >= A_DOUT) && (addr_i < A_DOUT + NP8);
  assign hit_din  = (addr_i >= A_DIN)  && (addr_i < A_DIN + NP8);
  assign guarded  = hit_cfg || (addr_i == A_FILT) || (addr_i == A_RISE) || (addr_i == A_FALL);
  assign locked   = soft_q | hard_q;
  assign blocked  = wr_en_i && guarded && locked;
  assign tick     = (pcnt_q == pre_q);
  assign stat_clr = (wr_en_i && addr_i == A_STAT) ? wdata_i[NFILT-1:0] : '0;

  always_comb begin
    cfg_d  = cfg_q;  dout_d = dout_q;
    soft_d = soft_q; hard_d = hard_q; werr_d = werr_q;
    fen_d  = fen_q;  ren_d  = ren_q;  fal_d  = fal_q;
    flen_d = flen_q; pre_d  = pre_q;
    pcnt_d = tick ? '0 : pcnt_q + 1'b1;
    if (wr_en_i) begin
      if (blocked) begin
        werr_d = 1'b1;
      end else begin
        if (hit_cfg) cfg_d[idx] = pin_cfg_t'(wdata_i[4:0]);
        if (addr_i == A_FILT) begin
          fen_d  = wdata_i[NFILT-1:0];
          flen_d = wdata_i[8 +: LEN_W];
          pre_d  = wdata_i[16 +: PRE_W];
        end
        if (addr_i == A_RISE) ren_d = wdata_i[NFILT-1:0];
        if (addr_i == A_FALL) fal_d = wdata_i[NFILT-1:0];
      end
      if (hit_dout) dout_d[idx] = wdata_i[0];
      if (addr_i == A_PORT_OUT) dout_d = wdata_i[NPINS-1:0];
      if (addr_i == A_LOCK) begin
        soft_d = wdata_i[0];
        hard_d = hard_q | wdata_i[1];
        if (wdata_i[2]) werr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_i) begin
    if (!rst_i) begin
      cfg_q  <= '0; dout_q <= '0;
      soft_q <= 1'b0; hard_q <= 1'b0; werr_q <= 1'b0;
      fen_q  <= '0; ren_q <= '0; fal_q <= '0;
      flen_q <= '0; pre_q <= '0; pcnt_q <= '0;
    end else begin
      cfg_q  <= cfg_d;  dout_q <= dout_d;
      soft_q <= soft_d; hard_q <= hard_d; werr_q <= werr_d;
      fen_q  <= fen_d;  ren_q  <= ren_d;  fal_q  <= fal_d;
      flen_q <= flen_d; pre_q  <= pre_d;  pcnt_q <= pcnt_d;
    end
  end

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_i), .d_i(pad_in_i), .q_o(sync_w)
  );

  for (genvar g = 0; g < NFILT; g++) begin : g_flt
    gpio_glitch_filter #(.LEN_W(LEN_W)) u_flt (
      .clk_i(clk_i), .rst_ni(rst_i), .en_i(fen_q[g]), .tick_i(tick),
      .len_i(flen_q), .din_i(sync_w[g]), .dout_o(flt_w[g])
    );
  end

  gpio_edge_flags #(.N(NFILT)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_i), .lvl_i(flt_w), .rise_en_i(ren_q),
    .fall_en_i(fal_q), .clr_i(stat_clr), .stat_o(stat_w)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pad_oe_o[p]          = cfg_q[p].dir && (cfg_q[p].func == 2'b00);
    assign pad_pull_o[2*p +: 2] = cfg_q[p].pull;
    assign pad_func_o[2*p +: 2] = cfg_q[p].func;
  end
  assign pad_out_o = dout_q;
  assign irq_o     = |stat_w;

  always_comb begin
    rdata_o = '0;
    if (hit_cfg)       rdata_o[4:0] = cfg_q[idx];
    else if (hit_dout) rdata_o[0]   = dout_q[idx];
    else if (hit_din)  rdata_o[0]   = sync_w[idx];
    else begin
      case (addr_i)
        A_PORT_OUT: rdata_o[NPINS-1:0] = dout_q;
        A_PORT_IN:  rdata_o[NPINS-1:0] = sync_w;
        A_LOCK:     rdata_o[2:0]       = {werr_q, hard_q, soft_q};
        A_FILT: begin
          rdata_o[NFILT-1:0]  = fen_q;
          rdata_o[8 +: LEN_W] = flen_q;
          rdata_o[16 +: PRE_W] = pre_q;
        end
        A_RISE:     rdata_o[NFILT-1:0] = ren_q;
        A_FALL:     rdata_o[NFILT-1:0] = fal_q;
        A_STAT:     rdata_o[NFILT-1:0] = stat_w;
        default:    rdata_o = '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wdata_i, addr_i};

  // R8
  hard_lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_i)
    hard_q |=> hard_q);

  // R7
  locked_cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_i)
    (wr_en_i && locked && hit_cfg) |=> $stable(pad_oe_o) && $stable(pad_pull_o));

  // R9
  locked_err_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_i)
    blocked |=> werr_q);

  // R3
  port_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_i)
    (wr_en_i && addr_i == A_PORT_OUT) |=> (pad_out_o == $past(wdata_i[NPINS-1:0])));
endmodule

// File: tb/gpio_lock_ctrl_tb.sv
module gpio_lock_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [2*NP-1:0] pad_pull, pad_func;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lock_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_pull_o(pad_pull), .pad_func_o(pad_func), .irq_o(irq)
  );

  // Behavioural reference model
  logic [4:0]    m_cfg [NP];
  logic [NP-1:0] m_dout, m_s1, m_s2;
  logic          m_soft, m_hard, m_werr, m_r1, m_r2, m_run, m_tick;
  logic [NF-1:0] m_fen, m_ren, m_fal, m_fo, m_prev, m_stat, m_clr;
  int            m_len, m_pre, m_pcnt;
  int            m_fc [NF];

  task automatic m_reset();
    for (int i = 0; i < NP; i++) m_cfg[i] = '0;
    for (int i = 0; i < NF; i++) m_fc[i] = 0;
    m_dout = '0; m_s1 = '0; m_s2 = '0;
    m_soft = 0; m_hard = 0; m_werr = 0;
    m_fen = '0; m_ren = '0; m_fal = '0; m_fo = '0; m_prev = '0; m_stat = '0;
    m_len = 0; m_pre = 0; m_pcnt = 0;
  endtask

  task automatic m_step();
    logic [NF-1:0] nfo;
    m_tick = (m_pcnt == m_pre);
    m_clr = (wr_en && addr == 8'h36) ? wdata[NF-1:0] : '0;
    nfo = m_fo;
    for (int i = 0; i < NF; i++) begin
      if ((m_fo[i] && !m_prev[i] && m_ren[i]) || (!m_fo[i] && m_prev[i] && m_fal[i]))
        m_stat[i] = 1'b1;
      else if (m_clr[i])
        m_stat[i] = 1'b0;
      if (!m_fen[i]) begin
        nfo[i] = m_s2[i]; m_fc[i] = 0;
      end else if (m_s2[i] == m_fo[i]) begin
        m_fc[i] = 0;
      end else if (m_tick) begin
        if (m_fc[i] == m_len) begin nfo[i] = m_s2[i]; m_fc[i] = 0; end
        else m_fc[i] = (m_fc[i] + 1) % 16;
      end
    end
    m_prev = m_fo;
    m_fo = nfo;
    m_pcnt = m_tick ? 0 : (m_pcnt + 1) % 256;
    m_s2 = m_s1;
    m_s1 = pad_in;
    if (wr_en) begin
      if ((addr < 8'h10 || addr == 8'h33 || addr == 8'h34 || addr == 8'h35) && (m_soft || m_hard))
        m_werr = 1'b1;
      else if (addr < 8'h10) m_cfg[addr] = wdata[4:0];
      else if (addr == 8'h33) begin
        m_fen = wdata[NF-1:0]; m_len = int'(wdata[11:8]); m_pre = int'(wdata[23:16]);
      end
      else if (addr == 8'h34) m_ren = wdata[NF-1:0];
      else if (addr == 8'h35) m_fal = wdata[NF-1:0];
      if (addr >= 8'h10 && addr < 8'h20) m_dout[addr-8'h10] = wdata[0];
      if (addr == 8'h30) m_dout = wdata[NP-1:0];
      if (addr == 8'h32) begin
        m_soft = wdata[0];
        if (wdata[1]) m_hard = 1'b1;
        if (wdata[2]) m_werr = 1'b0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_reset();
    end else begin
      m_run = m_r2;
      if (!m_run) m_reset(); else m_step();
      m_r2 = m_r1; m_r1 = 1'b1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    if (a < 8'h10) r[4:0] = m_cfg[a];
    else if (a < 8'h20) r[0] = m_dout[a-8'h10];
    else if (a < 8'h30) r[0] = m_s2[a-8'h20];
    else if (a == 8'h30) r[NP-1:0] = m_dout;
    else if (a == 8'h31) r[NP-1:0] = m_s2;
    else if (a == 8'h32) r[2:0] = {m_werr, m_hard, m_soft};
    else if (a == 8'h33) r = {8'h00, 8'(m_pre), 4'h0, 4'(m_len), 4'h0, m_fen};
    else if (a == 8'h34) r[NF-1:0] = m_ren;
    else if (a == 8'h35) r[NF-1:0] = m_fal;
    else if (a == 8'h36) r[NF-1:0] = m_stat;
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a < 8'h10) return "R2";
    if (a < 8'h20 || a == 8'h30) return "R3";
    if (a < 8'h30 || a == 8'h31) return "R4";
    if (a == 8'h32) return "R9";
    if (a == 8'h33) return "R5";
    if (a <= 8'h36) return "R6";
    return "R10";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NP-1:0]   e_oe;
      logic [2*NP-1:0] e_pull, e_func;
      for (int i = 0; i < NP; i++) begin
        e_oe[i] = m_cfg[i][0] && (m_cfg[i][4:3] == 2'b00);
        e_pull[2*i +: 2] = m_cfg[i][2:1];
        e_func[2*i +: 2] = m_cfg[i][4:3];
      end
      chk("R2 pad_oe", 32'(pad_oe), 32'(e_oe));
      chk("R2 pad_pull", pad_pull, e_pull);
      chk("R2 pad_func", pad_func, e_func);
      chk("R3 pad_out", 32'(pad_out), 32'(m_dout));
      chk("R6 irq", 32'(irq), 32'(|m_stat));
      chk(rd_tag(addr), rdata, exp_rd(addr));
    end
  end

  task automatic step1();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step1();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (2) step1();
    cmp_on = 1;
    repeat (2) step1();
    rst_n = 1'b1;
    repeat (4) step1();
    // R1 reset state
    rd_chk("R1 cfg0", 8'h00, 32'h0);
    rd_chk("R1 lock", 8'h32, 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 configuration: pins 4..15 outputs, pin 15 alternate function
    for (int i = 0; i < NP; i++)
      wr(8'(i), {27'h0, (i == 15) ? 2'b10 : 2'b00, 2'(i % 3), (i >= 4) ? 1'b1 : 1'b0});
    chk("R2 oe map", 32'(pad_oe), 32'h0000_7FF0);
    chk("R2 pull pin5", 32'(pad_pull[11:10]), 32'h2);

    // R3 pin and port views share storage
    wr(8'h30, 32'h0000_A5C3);
    chk("R3 port write", 32'(pad_out), 32'h0000_A5C3);
    wr(8'h10, 32'h0);
    rd_chk("R3 port after pin write", 8'h30, 32'h0000_A5C2);
    rd_chk("R3 pin1", 8'h11, 32'h1);

    // R4 sensed pad level, not latch
    pad_in = 16'h0F0F;
    repeat (3) step1();
    rd_chk("R4 port in", 8'h31, 32'h0000_0F0F);
    rd_chk("R4 pin9 driven low reads pad", 8'h29, 32'h1);

    // R5 filter: enable all, L=2, P=1
    wr(8'h33, 32'h0001_020F);
    wr(8'h34, 32'hF);
    wr(8'h35, 32'h3);
    wr(8'h36, 32'hF);
    pad_in[0] = 1'b0; step1(); step1(); pad_in[0] = 1'b1;
    repeat (12) step1();
    rd_chk("R5 glitch rejected", 8'h36, 32'h0);

    // R6 falling edges on pins 0,1 only
    pad_in[3:0] = 4'h0;
    repeat (20) step1();
    rd_chk("R6 fall status", 8'h36, 32'h3);
    chk("R6 irq high", 32'(irq), 32'h1);
    wr(8'h36, 32'h1);
    rd_chk("R6 w1c partial", 8'h36, 32'h2);
    wr(8'h36, 32'h2);
    chk("R6 irq low", 32'(irq), 32'h0);
    pad_in[3:0] = 4'hF;
    repeat (20) step1();
    rd_chk("R6 rise status", 8'h36, 32'hF);
    wr(8'h36, 32'hF);

    // R7 soft lock
    wr(8'h32, 32'h1);
    wr(8'h04, 32'h0);
    rd_chk("R7 cfg4 held", 8'h04, 32'h3);
    rd_chk("R9 err flag", 8'h32, 32'h5);
    wr(8'h30, 32'h0000_1234);
    chk("R9 data write while locked", 32'(pad_out), 32'h0000_1234);
    wr(8'h32, 32'h4);
    rd_chk("R9 err cleared", 8'h32, 32'h0);
    wr(8'h04, 32'h0);
    rd_chk("R7 cfg4 after unlock", 8'h04, 32'h0);

    // Mixed random traffic, compared against the model each clock
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      a = ($urandom % 8 == 0) ? 8'h5A : 8'($urandom % 8'h37);
      wdata = $urandom;
      if (a == 8'h32) wdata[1] = 1'b0;
      if (a == 8'h33) wdata[23:18] = '0;
      addr = a;
      wr_en = ($urandom % 2 == 0);
      if ($urandom % 4 == 0) pad_in = 16'($urandom);
      step1();
      wr_en = 1'b0;
    end

    // R8 hard lock
    wr(8'h32, 32'h4);
    wr(8'h06, 32'h0B);
    wr(8'h32, 32'h2);
    wr(8'h32, 32'h0);
    rd_chk("R8 hard stays", 8'h32, 32'h2);
    wr(8'h06, 32'h0);
    rd_chk("R8 cfg6 held", 8'h06, 32'h0B);
    rd_chk("R10 unmapped", 8'h7F, 32'h0);
    repeat (4) step1();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule